// File: doc/BRIEF.md
# Packet buffer page allocator

This block keeps track of which 256-byte pages of an on-chip Ethernet packet buffer belong to which packet. Host software asks for space with an allocate command that carries a page count coded as pages minus one. The block answers with a packet number, or with a failure flag when it cannot honour the request. A successful allocation raises an interrupt bit that the host clears by writing a one.

The block also keeps two queues of packet numbers. The receive queue is filled by the MAC and is read oldest first; a release command returns the pages of its head packet to the pool. The transmit queue is filled by an enqueue command. When the MAC reports that the head packet is sent, that packet is popped, and its pages are freed at once if autorelease is on. A transmit-drained interrupt rises when the last queued packet leaves.

Every command holds a busy flag for a fixed number of cycles. The packet data RAM, the MAC datapath and the PHY lie outside the block.

Top module: `pbuf_page_mmu`

## Requirements
- R1: After reset, busy_o, alloc_irq_o, tx_irq_o and alloc_fail_o are 0, rx_empty_o and tx_empty_o are 1, and free_pages_o equals PAGES.
- R2: A command is accepted when cmd_valid_i is high, busy_o is low and cmd_op_i is not 0. The opcodes are 1 allocate, 2 reset, 3 release receive head, 4 free the packet given on cmd_pkt_i, and 5 enqueue cmd_pkt_i for transmit. An allocate requests cmd_pages_i+1 pages. If enough pages are free and a packet number is unused, the block returns the lowest unused packet number on alloc_pkt_o with alloc_fail_o=0, and free_pages_o drops by the requested count.
- R3: An allocate fails when fewer pages are free than requested, or when every packet number is in use. alloc_fail_o is then 1, free_pages_o is unchanged and alloc_irq_o is not set.
- R4: alloc_irq_o is set when an allocation succeeds. It is cleared by a cycle with alloc_irq_clr_i=1, and a set in the same cycle wins over the clear.
- R5: An allocate holds busy_o high for exactly PAGES cycles and every other command for exactly 1 cycle. Commands presented while busy_o is high are ignored.
- R6: The free command returns every page owned by the given packet and makes that packet number unused again.
- R7: The reset command marks all pages free and all packet numbers unused, and it empties both queues.
- R8: The receive queue presents packet numbers pushed by rx_push_i oldest first on rx_head_o, with rx_empty_o=1 when it holds nothing. A release pops the head and frees its pages. A release on an empty queue has no effect.
- R9: A tx_done_i pulse pops the transmit head. If autorelease_i=1, the head's pages are freed; if autorelease_i=0, they stay owned. tx_irq_o sets when the pop empties the queue and clears on tx_irq_clr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode |
| cmd_pages_i | input | clog2(PAGES) | Requested page count minus one |
| cmd_pkt_i | input | clog2(PKTS) | Packet number for free and enqueue |
| busy_o | output | 1 | Command in progress |
| alloc_pkt_o | output | clog2(PKTS) | Packet number of last allocation |
| alloc_fail_o | output | 1 | Last allocation failed |
| alloc_irq_o | output | 1 | Allocation-done interrupt |
| alloc_irq_clr_i | input | 1 | Write-one clear of alloc_irq_o |
| rx_push_i | input | 1 | MAC pushes a received packet number |
| rx_pkt_i | input | clog2(PKTS) | Received packet number |
| rx_head_o | output | clog2(PKTS) | Oldest received packet |
| rx_empty_o | output | 1 | Receive queue empty |
| tx_done_i | input | 1 | MAC finished the transmit head |
| autorelease_i | input | 1 | Free pages on transmit completion |
| tx_head_o | output | clog2(PKTS) | Transmit queue head |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_irq_o | output | 1 | Transmit queue drained interrupt |
| tx_irq_clr_i | input | 1 | Write-one clear of tx_irq_o |
| free_pages_o | output | clog2(PAGES+1) | Number of free pages |

## Verification
The bench builds the block with PAGES=8 and PKTS=4. With only eight pages, every pair of back-to-back allocation sizes can be swept, so the boundary between just fitting and just failing is hit at every split of the pool. Four packet numbers make running out of packet numbers reachable while pages are still free. The short scan also keeps the busy-duration checks cheap, so each one is exact to the cycle.

// File: rtl/pbuf_mmu_pkg.sv
package pbuf_mmu_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_RELEASE = 3'd3,
    OP_FREE    = 3'd4,
    OP_ENQUEUE = 3'd5
  } mmu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_EXEC
  } mmu_st_e;
endpackage

// File: rtl/pbuf_first_set.sv
module pbuf_first_set #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = IW'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pbuf_fifo.sv
module pbuf_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 5,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          full, push_ok, pop_ok;

  assign empty_o = (cnt_o == '0);
  assign full    = (cnt_o == CW'(DEPTH));
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (!full || pop_ok);
  assign dout_o  = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr_i) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_o <= '0;
    end else begin
      if (push_ok) begin
        mem[wptr] <= din_i;
        wptr      <= wptr + 1'b1;
      end
      if (pop_ok) rptr <= rptr + 1'b1;
      cnt_o <= cnt_o + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/pbuf_page_mmu.sv
module pbuf_page_mmu
  import pbuf_mmu_pkg::*;
#(
  parameter int PAGES = 32,
  parameter int PKTS  = 32,
  localparam int PGW  = $clog2(PAGES),
  localparam int PKW  = $clog2(PKTS),
  localparam int CW   = $clog2(PAGES + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [2:0]     cmd_op_i,
  input  logic [PGW-1:0] cmd_pages_i,
  input  logic [PKW-1:0] cmd_pkt_i,
  output logic           busy_o,
  output logic [PKW-1:0] alloc_pkt_o,
  output logic           alloc_fail_o,
  output logic           alloc_irq_o,
  input  logic           alloc_irq_clr_i,
  input  logic           rx_push_i,
  input  logic [PKW-1:0] rx_pkt_i,
  output logic [PKW-1:0] rx_head_o,
  output logic           rx_empty_o,
  input  logic           tx_done_i,
  input  logic           autorelease_i,
  output logic [PKW-1:0] tx_head_o,
  output logic           tx_empty_o,
  output logic           tx_irq_o,
  input  logic           tx_irq_clr_i,
  output logic [CW-1:0]  free_pages_o
);
  localparam int QCW = $clog2(PKTS + 1);

  mmu_st_e        state;
  mmu_op_e        op_q;
  logic [PKW-1:0] pkt_q, cur_pkt;
  logic [PGW-1:0] scan_idx;
  logic [CW-1:0]  need;
  logic           scan_ok;

  logic [PAGES-1:0] pg_used;
  logic [PKW-1:0]   pg_owner [PAGES];
  logic [PKTS-1:0]  pk_used;

  logic [PKW-1:0] first_pkt;
  logic           pkt_avail;
  logic [QCW-1:0] rx_cnt, tx_cnt;

  logic cmd_go, exec, cmd_free_en, tx_pop, tx_free_en, start_ok;
  logic [PKW-1:0] cmd_free_pkt;
  logic [CW-1:0]  req_pages;

  pbuf_first_set #(.N(PKTS)) u_pick (
    .vec_i(~pk_used), .idx_o(first_pkt), .found_o(pkt_avail)
  );

  assign busy_o = (state != ST_IDLE);
  assign cmd_go = cmd_valid_i && !busy_o && (cmd_op_i != 3'd0);
  assign exec   = (state == ST_EXEC);

  always_comb begin
    free_pages_o = CW'(PAGES);
    for (int p = 0; p < PAGES; p++) free_pages_o -= CW'(pg_used[p]);
  end

  assign req_pages = CW'(cmd_pages_i) + 1'b1;
  assign start_ok  = pkt_avail && (free_pages_o >= req_pages);

  // command-side free: explicit packet or receive head
  assign cmd_free_en  = exec && ((op_q == OP_FREE) ||
                                 (op_q == OP_RELEASE && !rx_empty_o));
  assign cmd_free_pkt = (op_q == OP_FREE) ? pkt_q : rx_head_o;
  assign tx_pop       = tx_done_i && !tx_empty_o;
  assign tx_free_en   = tx_pop && autorelease_i;

  pbuf_fifo #(.DEPTH(PKTS), .W(PKW)) u_rxq (
    .clk_i, .rst_ni,
    .clr_i (exec && op_q == OP_RESET),
    .push_i(rx_push_i), .din_i(rx_pkt_i),
    .pop_i (exec && op_q == OP_RELEASE),
    .dout_o(rx_head_o), .empty_o(rx_empty_o), .cnt_o(rx_cnt)
  );

  pbuf_fifo #(.DEPTH(PKTS), .W(PKW)) u_txq (
    .clk_i, .rst_ni,
    .clr_i (exec && op_q == OP_RESET),
    .push_i(exec && op_q == OP_ENQUEUE), .din_i(pkt_q),
    .pop_i (tx_done_i),
    .dout_o(tx_head_o), .empty_o(tx_empty_o), .cnt_o(tx_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state        <= ST_IDLE;
      op_q         <= OP_NOP;
      pkt_q        <= '0;
      cur_pkt      <= '0;
      scan_idx     <= '0;
      need         <= '0;
      scan_ok      <= 1'b0;
      pg_used      <= '0;
      pk_used      <= '0;
      alloc_pkt_o  <= '0;
      alloc_fail_o <= 1'b0;
      alloc_irq_o  <= 1'b0;
      tx_irq_o     <= 1'b0;
      for (int p = 0; p < PAGES; p++) pg_owner[p] <= '0;
    end else begin
      // page returns
      for (int p = 0; p < PAGES; p++) begin
        if (pg_used[p] &&
            ((cmd_free_en && pg_owner[p] == cmd_free_pkt) ||
             (tx_free_en && pg_owner[p] == tx_head_o)))
          pg_used[p] <= 1'b0;
      end
      if (cmd_free_en) pk_used[cmd_free_pkt] <= 1'b0;
      if (tx_free_en)  pk_used[tx_head_o]    <= 1'b0;

      if (alloc_irq_clr_i) alloc_irq_o <= 1'b0;
      if (tx_irq_clr_i)    tx_irq_o    <= 1'b0;
      if (tx_pop && tx_cnt == QCW'(1) && !(exec && op_q == OP_ENQUEUE))
        tx_irq_o <= 1'b1;

      unique case (state)
        ST_IDLE: if (cmd_go) begin
          op_q  <= mmu_op_e'(cmd_op_i);
          pkt_q <= cmd_pkt_i;
          if (cmd_op_i == OP_ALLOC) begin
            state    <= ST_SCAN;
            scan_idx <= '0;
            need     <= req_pages;
            scan_ok  <= start_ok;
            cur_pkt  <= first_pkt;
            if (start_ok) pk_used[first_pkt] <= 1'b1;
          end else begin
            state <= ST_EXEC;
          end
        end
        ST_SCAN: begin
          if (scan_ok && need != '0 && !pg_used[scan_idx]) begin
            pg_used[scan_idx]  <= 1'b1;
            pg_owner[scan_idx] <= cur_pkt;
            need               <= need - 1'b1;
          end
          scan_idx <= scan_idx + 1'b1;
          if (scan_idx == PGW'(PAGES - 1)) begin
            state        <= ST_IDLE;
            alloc_pkt_o  <= cur_pkt;
            alloc_fail_o <= !scan_ok;
            if (scan_ok) alloc_irq_o <= 1'b1;
          end
        end
        ST_EXEC: begin
          state <= ST_IDLE;
          if (op_q == OP_RESET) begin
            pg_used <= '0;
            pk_used <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbuf_page_mmu_chk.sv
module pbuf_page_mmu_chk #(
  parameter int PAGES = 32,
  localparam int CW   = $clog2(PAGES + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [2:0]    cmd_op_i,
  input logic          busy_o,
  input logic          alloc_fail_o,
  input logic          alloc_irq_o,
  input logic          rx_push_i,
  input logic          rx_empty_o,
  input logic          tx_empty_o,
  input logic          tx_irq_o,
  input logic [CW-1:0] free_pages_o
);
  AST_CMD_TAKES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_o && cmd_op_i != 3'd0 |=> busy_o); // R5

  AST_POOL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_pages_o <= CW'(PAGES)); // R7

  AST_IRQ_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alloc_irq_o) |-> $past(busy_o) && !busy_o); // R4

  AST_FAIL_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) && alloc_fail_o && !$past(alloc_irq_o) |-> !alloc_irq_o); // R3

  AST_RX_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o && !rx_push_i |=> rx_empty_o); // R8

  AST_TXIRQ_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_irq_o) |-> tx_empty_o); // R9
endmodule

bind pbuf_page_mmu pbuf_page_mmu_chk #(.PAGES(PAGES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_op_i(cmd_op_i), .busy_o(busy_o), .alloc_fail_o(alloc_fail_o),
  .alloc_irq_o(alloc_irq_o), .rx_push_i(rx_push_i), .rx_empty_o(rx_empty_o),
  .tx_empty_o(tx_empty_o), .tx_irq_o(tx_irq_o), .free_pages_o(free_pages_o)
);

// File: tb/sim_pbuf_page_mmu.sv
module sim_pbuf_page_mmu;
  localparam int CLK_PERIOD = 10;
  localparam int PAGES = 8;
  localparam int PKTS  = 4;
  localparam int PGW = $clog2(PAGES);
  localparam int PKW = $clog2(PKTS);
  localparam int CW  = $clog2(PAGES + 1);

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, alloc_irq_clr = 0, rx_push = 0, tx_done = 0;
  logic autorel = 0, tx_irq_clr = 0;
  logic [2:0] cmd_op = 0;
  logic [PGW-1:0] cmd_pages = 0;
  logic [PKW-1:0] cmd_pkt = 0, rx_pkt = 0;
  logic busy, alloc_fail, alloc_irq, rx_empty, tx_empty, tx_irq;
  logic [PKW-1:0] alloc_pkt, rx_head, tx_head;
  logic [CW-1:0] free_pages;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbuf_page_mmu #(.PAGES(PAGES), .PKTS(PKTS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_pages_i(cmd_pages), .cmd_pkt_i(cmd_pkt), .busy_o(busy),
    .alloc_pkt_o(alloc_pkt), .alloc_fail_o(alloc_fail), .alloc_irq_o(alloc_irq),
    .alloc_irq_clr_i(alloc_irq_clr), .rx_push_i(rx_push), .rx_pkt_i(rx_pkt),
    .rx_head_o(rx_head), .rx_empty_o(rx_empty), .tx_done_i(tx_done),
    .autorelease_i(autorel), .tx_head_o(tx_head), .tx_empty_o(tx_empty),
    .tx_irq_o(tx_irq), .tx_irq_clr_i(tx_irq_clr), .free_pages_o(free_pages)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // issue a command and return the number of cycles busy stays high
  task automatic issue(input int op, input int pages, input int pkt, output int bc);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_pages = PGW'(pages); cmd_pkt = PKW'(pkt);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
    bc = 0;
    while (busy) begin bc++; @(negedge clk); end
  endtask

  task automatic clr_alloc_irq();
    @(negedge clk); alloc_irq_clr = 1;
    @(negedge clk); alloc_irq_clr = 0;
  endtask

  task automatic pulse_tx_done();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic push_rx(input int pkt);
    @(negedge clk); rx_push = 1; rx_pkt = PKW'(pkt);
    @(negedge clk); rx_push = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    // R1 reset state
    eq("R1 busy", busy, 0);
    eq("R1 free", free_pages, PAGES);
    eq("R1 rx_empty", rx_empty, 1);
    eq("R1 tx_empty", tx_empty, 1);
    eq("R1 irq", alloc_irq, 0);
    eq("R1 fail", alloc_fail, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3 sweep of all size pairs
    for (int a = 0; a < PAGES; a++) begin
      for (int b = 0; b < PAGES; b++) begin
        bit fits;
        issue(2, 0, 0, bc);
        eq("R7 reset busy", bc, 1);
        eq("R7 reset free", free_pages, PAGES);
        clr_alloc_irq();
        issue(1, a, 0, bc);
        eq("R5 alloc busy", bc, PAGES);
        eq("R2 first fail", alloc_fail, 0);
        eq("R2 first pkt", alloc_pkt, 0);
        eq("R2 first free", free_pages, PAGES - a - 1);
        eq("R4 irq set", alloc_irq, 1);
        clr_alloc_irq();
        eq("R4 irq clr", alloc_irq, 0);
        issue(1, b, 0, bc);
        fits = (a + b + 2) <= PAGES;
        if (fits) begin
          eq("R2 second fail", alloc_fail, 0);
          eq("R2 second pkt", alloc_pkt, 1);
          eq("R2 second free", free_pages, PAGES - a - b - 2);
          eq("R2 second irq", alloc_irq, 1);
        end else begin
          eq("R3 fail flag", alloc_fail, 1);
          eq("R3 free kept", free_pages, PAGES - a - 1);
          eq("R3 irq clear", alloc_irq, 0);
        end
      end
    end

    // R3 out of packet numbers while pages remain
    issue(2, 0, 0, bc);
    for (int i = 0; i < PKTS; i++) begin
      issue(1, 0, 0, bc);
      eq("R2 pkt seq", alloc_pkt, i);
    end
    clr_alloc_irq();
    issue(1, 0, 0, bc);
    eq("R3 no pkt fail", alloc_fail, 1);
    eq("R3 no pkt free", free_pages, PAGES - PKTS);
    eq("R3 no pkt irq", alloc_irq, 0);

    // R6 free packet 1 and reuse its number
    issue(4, 0, 1, bc);
    eq("R6 free busy", bc, 1);
    eq("R6 free pages", free_pages, PAGES - PKTS + 1);
    issue(1, 2, 0, bc);
    eq("R6 reuse pkt", alloc_pkt, 1);
    eq("R6 reuse free", free_pages, PAGES - PKTS - 2);

    // R4 set wins over clear held through completion
    issue(2, 0, 0, bc);
    clr_alloc_irq();
    @(negedge clk);
    alloc_irq_clr = 1; cmd_valid = 1; cmd_op = 1; cmd_pages = 0;
    @(negedge clk); cmd_valid = 0; cmd_op = 0;
    while (busy) @(negedge clk);
    alloc_irq_clr = 0;
    eq("R4 set wins", alloc_irq, 1);

    // R5 command during busy ignored: free of pkt 0 while pkt 1 allocating
    @(negedge clk);
    cmd_valid = 1; cmd_op = 1; cmd_pages = 1;
    @(negedge clk);
    cmd_op = 4; cmd_pkt = 0;
    @(negedge clk); cmd_valid = 0; cmd_op = 0;
    while (busy) @(negedge clk);
    eq("R5 ignored free", free_pages, PAGES - 3);
    eq("R5 pkt", alloc_pkt, 1);

    // R8 receive queue order and release
    issue(2, 0, 0, bc);
    issue(1, 1, 0, bc);           // pkt0: 2 pages
    issue(1, 0, 0, bc);           // pkt1: 1 page
    issue(3, 0, 0, bc);           // release on empty queue
    eq("R8 empty release", free_pages, PAGES - 3);
    push_rx(1);
    push_rx(0);
    eq("R8 not empty", rx_empty, 0);
    eq("R8 oldest", rx_head, 1);
    issue(3, 0, 0, bc);
    eq("R8 release busy", bc, 1);
    eq("R8 free after 1", free_pages, PAGES - 2);
    eq("R8 next head", rx_head, 0);
    issue(3, 0, 0, bc);
    eq("R8 free after 2", free_pages, PAGES);
    eq("R8 empty", rx_empty, 1);

    // R9 transmit with and without autorelease
    issue(1, 2, 0, bc);           // pkt0: 3 pages
    issue(5, 0, 0, bc);
    eq("R9 tx not empty", tx_empty, 0);
    eq("R9 tx head", tx_head, 0);
    autorel = 1;
    pulse_tx_done();
    eq("R9 autorelease free", free_pages, PAGES);
    eq("R9 drained irq", tx_irq, 1);
    eq("R9 tx empty", tx_empty, 1);
    @(negedge clk); tx_irq_clr = 1;
    @(negedge clk); tx_irq_clr = 0;
    eq("R9 irq clr", tx_irq, 0);
    issue(1, 1, 0, bc);           // pkt0 again: 2 pages
    eq("R9 pkt reuse", alloc_pkt, 0);
    issue(5, 0, 0, bc);
    autorel = 0;
    pulse_tx_done();
    eq("R9 no autorelease", free_pages, PAGES - 2);
    eq("R9 drained irq 2", tx_irq, 1);
    issue(4, 0, 0, bc);
    eq("R6 manual free", free_pages, PAGES);

    // R7 reset empties queues
    issue(1, 0, 0, bc);
    push_rx(0);
    issue(5, 0, 0, bc);
    issue(2, 0, 0, bc);
    eq("R7 rx cleared", rx_empty, 1);
    eq("R7 tx cleared", tx_empty, 1);
    eq("R7 pages", free_pages, PAGES);
    issue(1, 0, 0, bc);
    eq("R7 pkt numbers", alloc_pkt, 0);

    finish_run();
  end
endmodule